// File: doc/BRIEF.md
# Host-to-Controller Byte Mailbox

This block passes bytes in both directions between a host bus and an attached controller. The host writes bytes into a transmit queue, and the controller removes them one at a time through a pop strobe. The controller pushes bytes into a receive queue, and the host collects them by reading a data word. Both queues are parameterised and are eight entries deep by default. A host access is one strobed cycle with a write-enable, a word address, write data and registered read data. Read data is valid one clock after the strobe.

The host sees three 32-bit words. Word 0 holds request flags and interrupt enables. Word 1 is the data port, which carries payload bytes in bits 15:8. Word 2 holds status. Four conditions are tracked: transmit queue empty, transmit queue has space, receive queue holds data, and receive queue overrun. A request flag latches a condition until software acknowledges it. A single registered, level-sensitive interrupt line combines the enabled flags.

A typical driver enables the receive-data condition, waits for the interrupt, and reads the data word until the status shows the queue is drained. It then writes the receive-data bit to the status word to acknowledge the condition.

Top module: `fifo_mailbox`

## Requirements
- R1: After reset, irq_o is 0, all enables and request flags are 0, ctl_tx_valid_o is 0, and bus_rdata_o is 0. Status reads as 0x3 once the block is out of reset.
- R2: A host write to word 1 (byte offset 0x4) appends bits 15:8 to the transmit queue. ctl_tx_valid_o is high while the queue is non-empty, ctl_tx_data_o shows the oldest byte, and ctl_tx_pop_i removes that byte.
- R3: The transmit queue holds DEPTH bytes, and a write to a full queue is dropped. The live status bit 0 is transmit-empty and bit 1 is transmit-has-space.
- R4: A host read of word 1 returns the oldest received byte in bits 15:8 with all other bits 0, and removes that byte from the receive queue.
- R5: A read of word 1 while the receive queue is empty returns 0 and leaves the queue unchanged.
- R6: A controller push into a full receive queue discards the byte. It sets the sticky overrun flag, which is status bit 3, and also sets request bit 3.
- R7: The overrun status bit stays at 1 until a status write with bit 3 at 1 clears it. Status writes with bit 3 at 0 leave it set.
- R8: Word 0 (offset 0x0) reads with request flags in bits 3:0 and enables in bits 7:4, in the order transmit-empty, transmit-space, receive-data, overrun. A request flag is set in every cycle its condition holds and stays set after the condition ends. Status bit 2 is live receive-data.
- R9: A write to word 0 loads bits 7:4 into the enables. Each request flag whose bit 3:0 is written as 1 is cleared, unless its condition still holds in that cycle.
- R10: A write to word 2 (offset 0x8) clears each request flag whose bit is written as 1, with the same rule that a holding condition wins.
- R11: irq_o is the OR over the four conditions of request AND enable, delayed by one clock register.
- R12: Reads of word slots 3 to 7 (offsets 0xC to 0x1C) return 0, and writes to those slots change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Host access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte address; bits 4:2 select the word |
| bus_wdata_i | input | 32 | Host write data |
| bus_rdata_o | output | 32 | Host read data, registered |
| ctl_tx_pop_i | input | 1 | Controller removes the head transmit byte |
| ctl_tx_data_o | output | 8 | Head transmit byte |
| ctl_tx_valid_o | output | 1 | Transmit queue non-empty |
| ctl_rx_push_i | input | 1 | Controller pushes a receive byte |
| ctl_rx_data_i | input | 8 | Byte to push |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest state to reach is overrun combined with its acknowledgement. The receive queue must be filled to capacity by the controller and one more push issued. The sticky bit must then survive a drain of every entry, a read from the empty queue, and a status write that acknowledges only the receive-data bit. The stimulus does exactly this with directed controller pushes followed by host reads. It then checks that the queue returns the first DEPTH bytes in order and that only a write of status bit 3 clears the flag. The irq_o timing is probed separately, cycle by cycle, around one push and its acknowledgement.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned IDX_W    = ADDR_W - 2;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned BYTE_LSB = 8;
  localparam int unsigned NUM_COND = 4;

  typedef enum logic [IDX_W-1:0] {
    IDX_INT  = 3'd0,
    IDX_DATA = 3'd1,
    IDX_STAT = 3'd2
  } reg_idx_e;

  // bit position of each condition, shared by request, enable and status fields
  localparam int unsigned COND_TXE  = 0;
  localparam int unsigned COND_TXNF = 1;
  localparam int unsigned COND_RXNE = 2;
  localparam int unsigned COND_RXO  = 3;
endpackage

// File: rtl/mbox_byte_fifo.sv
module mbox_byte_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             drop_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign drop_o  = push_i & full_o;
  // empty queue presents zero so an empty read returns nothing stale
  assign data_o  = empty_o ? '0 : mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags #(
  parameter int unsigned NC = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NC-1:0] set_i,
  input  logic [NC-1:0] clr_i,
  input  logic          en_we_i,
  input  logic [NC-1:0] en_i,
  output logic [NC-1:0] req_o,
  output logic [NC-1:0] en_o,
  output logic          irq_o
);
  logic [NC-1:0] en_q;
  logic          irq_q;

  for (genvar g = 0; g < NC; g++) begin : g_req
    logic flag_q;
    // a condition present in the clearing cycle wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q <= 1'b0;
      else if (set_i[g])  flag_q <= 1'b1;
      else if (clr_i[g])  flag_q <= 1'b0;
    end
    assign req_o[g] = flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (en_we_i) en_q <= en_i;
      irq_q <= |(req_o & en_q);
    end
  end

  assign en_o  = en_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/fifo_mailbox.sv
module fifo_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              ctl_tx_pop_i,
  output logic [BYTE_W-1:0] ctl_tx_data_o,
  output logic              ctl_tx_valid_o,
  input  logic              ctl_rx_push_i,
  input  logic [BYTE_W-1:0] ctl_rx_data_i,
  output logic              irq_o
);
  localparam int unsigned NC = NUM_COND;
  localparam int unsigned PAD_INT  = DATA_W - 2 * NC;
  localparam int unsigned PAD_STAT = DATA_W - NC;
  localparam int unsigned PAD_HI   = DATA_W - BYTE_LSB - BYTE_W;

  logic [IDX_W-1:0] idx;
  logic wr_int, wr_data, wr_stat, rd_data, rd_any;

  assign idx     = bus_addr_i[ADDR_W-1:2];
  assign wr_int  = bus_sel_i &  bus_we_i & (idx == IDX_INT);
  assign wr_data = bus_sel_i &  bus_we_i & (idx == IDX_DATA);
  assign wr_stat = bus_sel_i &  bus_we_i & (idx == IDX_STAT);
  assign rd_any  = bus_sel_i & ~bus_we_i;
  assign rd_data = rd_any & (idx == IDX_DATA);

  // transmit path: host fills, controller drains
  logic [BYTE_W-1:0] tx_head;
  logic tx_empty, tx_full, tx_drop;

  mbox_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_data),
    .data_i  (bus_wdata_i[BYTE_LSB +: BYTE_W]),
    .pop_i   (ctl_tx_pop_i),
    .data_o  (tx_head),
    .empty_o (tx_empty),
    .full_o  (tx_full),
    .drop_o  (tx_drop)
  );

  assign ctl_tx_data_o  = tx_head;
  assign ctl_tx_valid_o = ~tx_empty;

  // receive path: controller fills, host drains
  logic [BYTE_W-1:0] rx_head;
  logic rx_empty, rx_full, rx_ovf;

  mbox_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (ctl_rx_push_i),
    .data_i  (ctl_rx_data_i),
    .pop_i   (rd_data),
    .data_o  (rx_head),
    .empty_o (rx_empty),
    .full_o  (rx_full),
    .drop_o  (rx_ovf)
  );

  // sticky overrun, cleared only through the status word
  logic ovf_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ovf_q <= 1'b0;
    else if (rx_ovf)                            ovf_q <= 1'b1;
    else if (wr_stat && bus_wdata_i[COND_RXO])  ovf_q <= 1'b0;
  end

  logic [NC-1:0] cond, clr, req_w, en_w, live;
  always_comb begin
    cond            = '0;
    cond[COND_TXE]  = tx_empty;
    cond[COND_TXNF] = ~tx_full;
    cond[COND_RXNE] = ~rx_empty;
    cond[COND_RXO]  = rx_ovf;
    live            = cond;
    live[COND_RXO]  = ovf_q;
  end

  assign clr = (wr_int | wr_stat) ? bus_wdata_i[NC-1:0] : '0;

  mbox_flags #(.NC(NC)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (cond),
    .clr_i   (clr),
    .en_we_i (wr_int),
    .en_i    (bus_wdata_i[2*NC-1:NC]),
    .req_o   (req_w),
    .en_o    (en_w),
    .irq_o   (irq_o)
  );

  // registered read port
  logic [DATA_W-1:0] rd_mux, rdata_q;
  always_comb begin
    rd_mux = '0;
    case (idx)
      IDX_INT:  rd_mux = {{PAD_INT{1'b0}}, en_w, req_w};
      IDX_DATA: rd_mux = {{PAD_HI{1'b0}}, rx_head, {BYTE_LSB{1'b0}}};
      IDX_STAT: rd_mux = {{PAD_STAT{1'b0}}, live};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_any) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;

  logic unused_bits;
  assign unused_bits = ^{bus_addr_i[1:0], bus_wdata_i[DATA_W-1:BYTE_LSB+BYTE_W], tx_drop};
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_push_i,
  input logic        rx_full_i,
  input logic        rx_empty_i,
  input logic        rd_data_i,
  input logic        ovf_i,
  input logic        stat_clr_ovf_i,
  input logic [3:0]  req_i,
  input logic [3:0]  en_i,
  input logic        irq_i,
  input logic        tx_full_i,
  input logic        tx_empty_i,
  input logic [31:0] rdata_i
);
  assert_overrun_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_full_i) |=> (ovf_i && req_i[3]));

  assert_overrun_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !stat_clr_ovf_i) |=> ovf_i);

  assert_empty_read_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && rx_empty_i) |=> (rdata_i == 32'd0));

  assert_irq_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(req_i & en_i)) |=> !irq_i);

  assert_irq_high_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(req_i & en_i)) |=> irq_i);

  assert_tx_state_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_full_i && tx_empty_i));

  assert_rx_state_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_full_i && rx_empty_i));
endmodule

bind fifo_mailbox mbox_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rx_push_i      (ctl_rx_push_i),
  .rx_full_i      (rx_full),
  .rx_empty_i     (rx_empty),
  .rd_data_i      (rd_data),
  .ovf_i          (ovf_q),
  .stat_clr_ovf_i (wr_stat && bus_wdata_i[3]),
  .req_i          (req_w),
  .en_i           (en_w),
  .irq_i          (irq_o),
  .tx_full_i      (tx_full),
  .tx_empty_i     (tx_empty),
  .rdata_i        (bus_rdata_o)
);

// File: tb/fifo_mailbox_tb.sv
`timescale 1ns/1ps
module fifo_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx_pop = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        irq;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  fifo_mailbox u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .ctl_tx_pop_i(tx_pop), .ctl_tx_data_o(tx_data), .ctl_tx_valid_o(tx_valid),
    .ctl_rx_push_i(rx_push), .ctl_rx_data_i(rx_data), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; d = rdata;
  endtask

  task automatic rx_in(input logic [7:0] b);
    @(negedge clk); rx_push = 1'b1; rx_data = b;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic tx_out(output logic v, output logic [7:0] d);
    @(negedge clk); v = tx_valid; d = tx_data; tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [4:0]  a;
    logic [31:0] d;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'h00, 32'h0000_0003, 8'd8},   // R8 txe/txnf flags latched
    '{1'b0, 5'h08, 32'h0000_0003, 8'd1},   // R1 status after reset
    '{1'b1, 5'h00, 32'h0000_0003, 8'd9},   // R9 clear while conditions hold
    '{1'b0, 5'h00, 32'h0000_0003, 8'd9},   // R9 held conditions win
    '{1'b1, 5'h04, 32'hFFFF_ABFF, 8'd2},   // R2 push 0xAB
    '{1'b0, 5'h08, 32'h0000_0002, 8'd3},   // R3 txe live low
    '{1'b0, 5'h00, 32'h0000_0003, 8'd8},   // R8 txe request sticky
    '{1'b1, 5'h00, 32'h0000_0001, 8'd9},   // R9 clear txe
    '{1'b0, 5'h00, 32'h0000_0002, 8'd9},   // R9 txe cleared
    '{1'b0, 5'h04, 32'h0000_0000, 8'd5},   // R5 empty read
    '{1'b0, 5'h0C, 32'h0000_0000, 8'd12},  // R12 reserved read
    '{1'b1, 5'h10, 32'hFFFF_FFFF, 8'd12},  // R12 reserved write
    '{1'b0, 5'h00, 32'h0000_0002, 8'd12}   // R12 nothing changed
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    logic        v;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'b0, irq}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'd0);
    chk("R1 rdata", rdata, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_wr(VEC[i].a, VEC[i].d);
      else begin
        bus_rd(VEC[i].a, r);
        chk($sformatf("R%0d vec%0d", VEC[i].tag, i), r, VEC[i].d);
      end
    end

    // R2: controller sees written byte
    tx_out(v, b);
    chk("R2 valid", {31'b0, v}, 32'd1);
    chk("R2 data", {24'b0, b}, 32'hAB);
    @(negedge clk);
    chk("R2 drained", {31'b0, tx_valid}, 32'd0);

    // R3: fill transmit queue, ninth write dropped
    for (int i = 0; i < 9; i++) bus_wr(5'h04, {16'h0, 8'h20 + 8'(i), 8'h0});
    bus_rd(5'h08, r);
    chk("R3 full status", r & 32'h3, 32'h0);
    for (int i = 0; i < 8; i++) begin
      tx_out(v, b);
      chk("R3 order", {23'b0, v, b}, {23'b0, 1'b1, 8'h20 + 8'(i)});
    end
    @(negedge clk);
    chk("R3 drop", {31'b0, tx_valid}, 32'd0);

    // R11: irq two cycles after push
    bus_wr(5'h00, 32'h0000_0040);
    rx_in(8'h5A);
    chk("R11 irq edge0", {31'b0, irq}, 32'd0);
    @(negedge clk);
    chk("R11 irq edge1", {31'b0, irq}, 32'd0);
    @(negedge clk);
    chk("R11 irq edge2", {31'b0, irq}, 32'd1);
    bus_rd(5'h04, r);
    chk("R4 head", r, 32'h0000_5A00);
    chk("R10 flag sticky after drain", {31'b0, irq}, 32'd1);
    bus_wr(5'h08, 32'h0000_0004);
    chk("R10 irq before clear", {31'b0, irq}, 32'd1);
    @(negedge clk);
    chk("R10 irq after ack", {31'b0, irq}, 32'd0);

    // R6/R7: overrun
    for (int i = 0; i < 8; i++) rx_in(8'h10 + 8'(i));
    rx_in(8'h99);
    bus_rd(5'h08, r);
    chk("R6 status", r & 32'hC, 32'hC);
    bus_rd(5'h00, r);
    chk("R6 int word", r & 32'hFC, 32'h4C);
    for (int i = 0; i < 8; i++) begin
      bus_rd(5'h04, r);
      chk("R4 order", r, {16'h0, 8'h10 + 8'(i), 8'h0});
    end
    bus_rd(5'h04, r);
    chk("R5 empty after drain", r, 32'd0);
    bus_rd(5'h08, r);
    chk("R7 ovf held", r & 32'hC, 32'h8);
    bus_wr(5'h08, 32'h0000_0004);
    bus_rd(5'h08, r);
    chk("R7 ovf survives other ack", r & 32'h8, 32'h8);
    bus_wr(5'h08, 32'h0000_0008);
    bus_rd(5'h08, r);
    chk("R7 ovf cleared", r & 32'hC, 32'h0);
    bus_rd(5'h00, r);
    chk("R10 req bits cleared", r & 32'hFC, 32'h40);
    chk("R11 irq low", {31'b0, irq}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule